// File: doc/BRIEF.md
# Per-Line Sprite Evaluator

This block prepares the sprite work for one scanline while the previous line is still finishing. A strobe at the start of the line makes it walk a small cache of 64 sprite vertical positions. It tests two entries per clock against the line that is about to be displayed. Every sprite that covers that line takes a slot in a 16-entry list. Slots are handed out from the top index downward, so the lowest-numbered sprite always sits in slot 15.

Once the scan is over, a second phase walks the slot list from slot 15 downward. For each slot it reads two bytes from the sprite attribute area in video memory: the horizontal position first, then the tile number. It then emits one draw entry, which holds the X position, the byte address of the pattern row inside the tile and a descending entry number. The renderer accepts a limited number of draw entries. When a selected sprite is still waiting and no entry is left, an overflow flag is raised and the phase ends.

The vertical cache is filled by snooping the CPU's video-memory writes. Only writes that land in the first 64 bytes of the attribute area are kept.

Top module: `sprite_line_eval`

## Requirements
- R1: The line tested is `cur_line + 1` modulo 256, captured on `line_start`. A current line of 255 therefore tests line 0.
- R2: A sprite with cached position Y is selected when Y ≤ target < Y + H, with no wrap past 255. H is 16 when `tall_mode` is 1 and 8 otherwise.
- R3: The slot list holds at most SLOTS (16) sprites, and scanning stops once every slot is taken. Sprites are placed in table order, so draw entries come out lowest table index first.
- R4: Draw entries appear as single-cycle `draw_valid` pulses. `draw_num` counts down from MAX_DRAWS−1 (7) for the first entry. No read or draw activity occurs while `eval_done` is high.
- R5: The attribute area starts at `attr_page` × 256. Sprite n's X byte is read from area + 0x80 + 2n and its tile byte from the next address. `mem_rd_data` returns the byte of the address requested one cycle earlier.
- R6: The pattern address is tile × 32 + 0x2000·`pat_hi` + (target − Y) × 4, truncated to 14 bits.
- R7: `sprite_overflow` rises when a selected sprite remains after MAX_DRAWS entries have been emitted. It then stays high until the next `line_start`, and stays low whenever the number selected is at most MAX_DRAWS.
- R8: A cache write with `ywr_en` is kept only if `ywr_addr` lies in [area, area + 64), and it then sets entry `ywr_addr[5:0]`. Writes elsewhere, including area + 64 and other pages, leave every entry unchanged.
- R9: `line_start` restarts evaluation from table index 0 with all slots free. One cycle later, `sprite_overflow` and `eval_done` are low.
- R10: After reset, `draw_valid`, `sprite_overflow` and `eval_done` are low.
- R11: The scan consumes two table entries per clock. With no sprite selected, `eval_done` is first seen high 34 cycles after the edge that samples `line_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_start | input | 1 | Strobe that restarts evaluation for a new line |
| cur_line | input | 8 | Line currently displayed |
| tall_mode | input | 1 | 1 selects 16-line sprites, 0 selects 8-line sprites |
| attr_page | input | 6 | Attribute area page (area starts at attr_page × 256) |
| pat_hi | input | 1 | Selects the upper 8 KB pattern half |
| ywr_en | input | 1 | CPU video-memory write strobe, snooped by the cache |
| ywr_addr | input | 14 | CPU write byte address |
| ywr_data | input | 8 | CPU write data |
| mem_rd_en | output | 1 | Attribute read request |
| mem_rd_addr | output | 14 | Attribute read byte address |
| mem_rd_data | input | 8 | Read data, one cycle after the request |
| draw_valid | output | 1 | One draw entry is presented this cycle |
| draw_x | output | 8 | Horizontal position of the entry |
| draw_addr | output | 14 | Pattern row byte address of the entry |
| draw_num | output | 3 | Draw entry number, counting down |
| sprite_overflow | output | 1 | More sprites selected than draw entries |
| eval_done | output | 1 | Evaluation of this line is finished |

## Verification
A corrupted scan index or free-slot count changes which sprites reach the draw list, or changes how long the scan takes. That shows up as a wrong X/address sequence and a shifted `eval_done` before the line ends. A wrong fetch pointer or draw counter shows up on the next `draw_valid` as a wrong X, address or entry number, or as a misplaced overflow. A bad cache entry stays hidden until a line crosses that sprite's rows, which is why the directed lines place sprites at the exact top and bottom rows of their height.

// File: rtl/slev_pkg.sv
// Shared constants and types for the per-line sprite evaluator.
// Assumes a 14-bit byte-addressed video memory.
package slev_pkg;
    localparam int VA_W = 14;

    typedef enum logic [2:0] {
        F_OFF,
        F_WAIT,
        F_CHECK,
        F_TILE,
        F_EMIT,
        F_DONE
    } fetch_state_t;
endpackage

// File: rtl/slev_ycache.sv
// Vertical-position cache. Snoops CPU video-memory writes and keeps the ones
// that land in the first ENTRIES bytes of the attribute page.
// Assumes ENTRIES is a power of two no larger than 128. Two combinational
// read ports serve the scanner.
module slev_ycache #(
    parameter int ENTRIES = 64,
    localparam int IW = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [13:0]   wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [5:0]    attr_page,
    input  logic [IW-1:0] rd_a,
    input  logic [IW-1:0] rd_b,
    output logic [7:0]    y_a,
    output logic [7:0]    y_b
);
    logic [7:0] ymem [ENTRIES];
    logic       in_window;

    // decide whether a write falls inside the cached window
    assign in_window = (wr_addr[13:8] == attr_page) && (wr_addr[7:IW] == '0);

    // store captured writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) ymem[i] <= '0;
        end else if (wr_en && in_window) begin
            ymem[wr_addr[IW-1:0]] <= wr_data;
        end
    end

    assign y_a = ymem[rd_a];
    assign y_b = ymem[rd_b];
endmodule

// File: rtl/slev_scan.sv
// Scanner. Tests two cached positions per clock against the next line and
// fills the slot list from the highest slot downward. Stops when the table
// is exhausted or every slot is taken.
// Assumes line_start is a single-cycle strobe.
module slev_scan #(
    parameter int ENTRIES = 64,
    parameter int SLOTS   = 16,
    localparam int IW = $clog2(ENTRIES),
    localparam int SW = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_start,
    input  logic [7:0]    cur_line,
    input  logic          tall_mode,
    output logic [IW-1:0] yrd_a,
    output logic [IW-1:0] yrd_b,
    input  logic [7:0]    y_a,
    input  logic [7:0]    y_b,
    output logic [7:0]    target,
    output logic          busy,
    output logic [IW:0]   idx,
    output logic [SW:0]   free_cnt,
    input  logic [SW-1:0] rd_sel,
    output logic [IW-1:0] rd_idx,
    output logic [7:0]    rd_y
);
    localparam logic [SW:0]   ONE_F  = 1;
    localparam logic [SW:0]   ALL_F  = SLOTS;
    localparam logic [IW:0]   ONE_I  = 1;
    localparam logic [IW:0]   TWO_I  = 2;
    localparam logic [IW:0]   END_I  = ENTRIES;
    localparam logic [IW-1:0] ONE_R  = 1;

    logic [IW-1:0] slot_idx [SLOTS];
    logic [7:0]    slot_y   [SLOTS];
    logic          tall_q;
    logic          hit_a, hit_b, claim_a, claim_b, test_b, busy_n;
    logic [SW:0]   free_a, free_b, sa, sb;
    logic [IW:0]   idx_n;

    function automatic logic y_hit(input logic [7:0] y, input logic [7:0] t,
                                   input logic tall);
        logic [7:0] row;
        row = t - y;
        return (t >= y) && (tall ? (row < 8'd16) : (row < 8'd8));
    endfunction

    assign yrd_a = idx[IW-1:0];
    assign yrd_b = idx[IW-1:0] + ONE_R;

    // pair evaluation and slot bookkeeping for this cycle
    always_comb begin
        hit_a   = y_hit(y_a, target, tall_q);
        hit_b   = y_hit(y_b, target, tall_q);
        claim_a = busy && hit_a;
        free_a  = claim_a ? free_cnt - ONE_F : free_cnt;
        test_b  = busy && (free_a != '0);
        claim_b = test_b && hit_b;
        free_b  = claim_b ? free_a - ONE_F : free_a;
        idx_n   = idx + (test_b ? TWO_I : ONE_I);
        busy_n  = (idx_n < END_I) && (free_b != '0);
        sa      = free_cnt - ONE_F;
        sb      = free_a - ONE_F;
    end

    // scan control: restart on strobe, advance while busy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            idx      <= '0;
            free_cnt <= ALL_F;
            target   <= '0;
            tall_q   <= 1'b0;
        end else if (line_start) begin
            busy     <= 1'b1;
            idx      <= '0;
            free_cnt <= ALL_F;
            target   <= cur_line + 8'd1;
            tall_q   <= tall_mode;
        end else if (busy) begin
            idx      <= idx_n;
            free_cnt <= free_b;
            busy     <= busy_n;
        end
    end

    // slot list writes
    always_ff @(posedge clk) begin
        if (claim_a) begin
            slot_idx[sa[SW-1:0]] <= yrd_a;
            slot_y[sa[SW-1:0]]   <= y_a;
        end
        if (claim_b) begin
            slot_idx[sb[SW-1:0]] <= yrd_b;
            slot_y[sb[SW-1:0]]   <= y_b;
        end
    end

    assign rd_idx = slot_idx[rd_sel];
    assign rd_y   = slot_y[rd_sel];
endmodule

// File: rtl/slev_fetch.sv
// Fetcher. Walks occupied slots from the top down and reads each sprite's
// X and tile bytes (read data one cycle after the request). Emits one draw
// entry per sprite and flags overflow when the draw entries run out.
// Assumes the scanner holds the slot list stable once it is idle.
module slev_fetch import slev_pkg::*; #(
    parameter int ENTRIES   = 64,
    parameter int SLOTS     = 16,
    parameter int MAX_DRAWS = 8,
    localparam int IW  = $clog2(ENTRIES),
    localparam int SW  = $clog2(SLOTS),
    localparam int DCW = $clog2(MAX_DRAWS + 1),
    localparam int DNW = (MAX_DRAWS > 1) ? $clog2(MAX_DRAWS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            line_start,
    input  logic            scan_busy,
    input  logic [SW:0]     free_cnt,
    input  logic [7:0]      target,
    input  logic [IW-1:0]   slot_idx,
    input  logic [7:0]      slot_y,
    input  logic [5:0]      attr_page,
    input  logic            pat_hi,
    input  logic [7:0]      mem_rd_data,
    output logic [SW-1:0]   slot_sel,
    output logic            mem_rd_en,
    output logic [VA_W-1:0] mem_rd_addr,
    output logic            draw_valid,
    output logic [7:0]      draw_x,
    output logic [VA_W-1:0] draw_addr,
    output logic [DNW-1:0]  draw_num,
    output logic            overflow,
    output logic            done
);
    localparam logic [SW:0]  ONE_P = 1;
    localparam logic [SW:0]  ALL_P = SLOTS;
    localparam logic [DCW-1:0] ONE_D = 1;
    localparam logic [DCW-1:0] ALL_D = MAX_DRAWS;

    fetch_state_t   state;
    logic [SW:0]    pos;
    logic [DCW-1:0] draws;
    logic [DCW-1:0] draws_m1;
    logic [7:0]     x_hold;
    logic [7:0]     row8;
    logic [SW:0]    pos_m1;
    logic           more;

    assign pos_m1   = pos - ONE_P;
    assign slot_sel = pos_m1[SW-1:0];
    assign more     = pos > free_cnt;
    assign draws_m1 = draws - ONE_D;
    assign row8     = target - slot_y;

    // attribute read request for the X byte or the tile byte
    always_comb begin
        mem_rd_en   = ((state == F_CHECK) && more && (draws != '0)) || (state == F_TILE);
        mem_rd_addr = {attr_page, 8'h80} | (VA_W'(slot_idx) << 1)
                    | {{(VA_W-1){1'b0}}, state == F_TILE};
    end

    // fetch sequencing, draw output and overflow flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= F_OFF;
            pos        <= ALL_P;
            draws      <= ALL_D;
            x_hold     <= '0;
            draw_valid <= 1'b0;
            draw_x     <= '0;
            draw_addr  <= '0;
            draw_num   <= '0;
            overflow   <= 1'b0;
        end else if (line_start) begin
            state      <= F_WAIT;
            draw_valid <= 1'b0;
            overflow   <= 1'b0;
        end else begin
            draw_valid <= 1'b0;
            unique case (state)
                F_WAIT: if (!scan_busy) begin
                    pos   <= ALL_P;
                    draws <= ALL_D;
                    state <= F_CHECK;
                end
                F_CHECK: begin
                    if (!more) begin
                        state <= F_DONE;
                    end else if (draws == '0) begin
                        overflow <= 1'b1;
                        state    <= F_DONE;
                    end else begin
                        state <= F_TILE;
                    end
                end
                F_TILE: begin
                    x_hold <= mem_rd_data;
                    state  <= F_EMIT;
                end
                F_EMIT: begin
                    draw_valid <= 1'b1;
                    draw_x     <= x_hold;
                    draw_addr  <= {pat_hi, 13'd0} + {1'b0, mem_rd_data, 5'd0}
                                + {8'd0, row8[3:0], 2'd0};
                    draw_num   <= draws_m1[DNW-1:0];
                    draws      <= draws_m1;
                    pos        <= pos_m1;
                    state      <= F_CHECK;
                end
                default: ;
            endcase
        end
    end

    assign done = (state == F_DONE);
endmodule

// File: rtl/sprite_line_eval.sv
// Per-line sprite evaluator top. Joins the position cache, the scanner and
// the fetcher. Assumes the attribute read port answers one cycle after a
// request and that line_start comes once per line.
module sprite_line_eval import slev_pkg::*; #(
    parameter int ENTRIES   = 64,
    parameter int SLOTS     = 16,
    parameter int MAX_DRAWS = 8,
    localparam int DNW = (MAX_DRAWS > 1) ? $clog2(MAX_DRAWS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            line_start,
    input  logic [7:0]      cur_line,
    input  logic            tall_mode,
    input  logic [5:0]      attr_page,
    input  logic            pat_hi,
    input  logic            ywr_en,
    input  logic [VA_W-1:0] ywr_addr,
    input  logic [7:0]      ywr_data,
    output logic            mem_rd_en,
    output logic [VA_W-1:0] mem_rd_addr,
    input  logic [7:0]      mem_rd_data,
    output logic            draw_valid,
    output logic [7:0]      draw_x,
    output logic [VA_W-1:0] draw_addr,
    output logic [DNW-1:0]  draw_num,
    output logic            sprite_overflow,
    output logic            eval_done
);
    localparam int IW = $clog2(ENTRIES);
    localparam int SW = $clog2(SLOTS);

    logic [IW-1:0] yrd_a, yrd_b, slot_idx;
    logic [7:0]    y_a, y_b, slot_y, target;
    logic          scan_busy;
    logic [IW:0]   scan_idx;
    logic [SW:0]   scan_free;
    logic [SW-1:0] slot_sel;

    slev_ycache #(.ENTRIES(ENTRIES)) u_cache (
        .clk(clk), .rst_n(rst_n), .wr_en(ywr_en), .wr_addr(ywr_addr),
        .wr_data(ywr_data), .attr_page(attr_page), .rd_a(yrd_a), .rd_b(yrd_b),
        .y_a(y_a), .y_b(y_b)
    );

    slev_scan #(.ENTRIES(ENTRIES), .SLOTS(SLOTS)) u_scan (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .cur_line(cur_line),
        .tall_mode(tall_mode), .yrd_a(yrd_a), .yrd_b(yrd_b), .y_a(y_a), .y_b(y_b),
        .target(target), .busy(scan_busy), .idx(scan_idx), .free_cnt(scan_free),
        .rd_sel(slot_sel), .rd_idx(slot_idx), .rd_y(slot_y)
    );

    slev_fetch #(.ENTRIES(ENTRIES), .SLOTS(SLOTS), .MAX_DRAWS(MAX_DRAWS)) u_fetch (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .scan_busy(scan_busy),
        .free_cnt(scan_free), .target(target), .slot_idx(slot_idx), .slot_y(slot_y),
        .attr_page(attr_page), .pat_hi(pat_hi), .mem_rd_data(mem_rd_data),
        .slot_sel(slot_sel), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .draw_valid(draw_valid), .draw_x(draw_x), .draw_addr(draw_addr),
        .draw_num(draw_num), .overflow(sprite_overflow), .done(eval_done)
    );
endmodule

// File: rtl/slev_checker.sv
// Property checker for the sprite evaluator, attached to the top by bind.
module slev_checker #(
    parameter int ENTRIES = 64,
    parameter int SLOTS   = 16,
    localparam int IW = $clog2(ENTRIES),
    localparam int SW = $clog2(SLOTS)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          line_start,
    input logic          mem_rd_en,
    input logic [13:0]   mem_rd_addr,
    input logic [5:0]    attr_page,
    input logic          draw_valid,
    input logic [13:0]   draw_addr,
    input logic          sprite_overflow,
    input logic          eval_done,
    input logic          scan_busy,
    input logic [IW:0]   scan_idx,
    input logic [SW:0]   scan_free
);
    localparam logic [IW:0] TWO   = 2;
    localparam logic [SW:0] LIMIT = SLOTS;

    p_reset_quiet_r10: assert property (@(posedge clk)
        !rst_n |=> (!draw_valid && !sprite_overflow && !eval_done));

    p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> (!sprite_overflow && !eval_done));

    p_overflow_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sprite_overflow && !line_start) |=> sprite_overflow);

    p_row_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
        draw_valid |-> (draw_addr[1:0] == 2'b00));

    p_attr_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> ((mem_rd_addr[13:8] == attr_page) && mem_rd_addr[7]));

    p_done_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        eval_done |-> (!mem_rd_en && !draw_valid));

    p_slot_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        scan_free <= LIMIT);

    p_pair_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_busy && !line_start) |=> (!scan_busy || line_start
                                        || scan_idx == $past(scan_idx) + TWO));
endmodule

bind sprite_line_eval slev_checker #(.ENTRIES(ENTRIES), .SLOTS(SLOTS)) u_chk (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .attr_page(attr_page), .draw_valid(draw_valid),
    .draw_addr(draw_addr), .sprite_overflow(sprite_overflow), .eval_done(eval_done),
    .scan_busy(scan_busy), .scan_idx(scan_idx), .scan_free(scan_free)
);

// File: tb/tb_sprite_line_eval.sv
module tb_sprite_line_eval;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_start = 1'b0;
    logic [7:0]  cur_line = '0;
    logic        tall_mode = 1'b0;
    logic [5:0]  attr_page = 6'h1E;
    logic        pat_hi = 1'b0;
    logic        ywr_en = 1'b0;
    logic [13:0] ywr_addr = '0;
    logic [7:0]  ywr_data = '0;
    logic        mem_rd_en;
    logic [13:0] mem_rd_addr;
    logic [7:0]  mem_rd_data = '0;
    logic        draw_valid;
    logic [7:0]  draw_x;
    logic [13:0] draw_addr;
    logic [2:0]  draw_num;
    logic        sprite_overflow;
    logic        eval_done;

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0] ymodel [64];
    int got_n, got_x [8], got_a [8], got_num [8];
    int exp_n, exp_x [8], exp_a [8];
    bit exp_ovf;
    int last_cycles;

    always #10 clk = ~clk;

    sprite_line_eval dut (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .cur_line(cur_line),
        .tall_mode(tall_mode), .attr_page(attr_page), .pat_hi(pat_hi),
        .ywr_en(ywr_en), .ywr_addr(ywr_addr), .ywr_data(ywr_data),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .draw_valid(draw_valid), .draw_x(draw_x), .draw_addr(draw_addr),
        .draw_num(draw_num), .sprite_overflow(sprite_overflow), .eval_done(eval_done)
    );

    function automatic logic [7:0] xval(input int n);
        return 8'((n * 3 + 1) & 255);
    endfunction
    function automatic logic [7:0] tval(input int n);
        return 8'((n * 5 + 7) & 255);
    endfunction

    // attribute memory model: answers only inside the X/tile half of the page
    always @(posedge clk) begin
        if (mem_rd_en) begin
            if (mem_rd_addr[13:8] == attr_page && mem_rd_addr[7])
                mem_rd_data <= mem_rd_addr[0] ? tval(int'(mem_rd_addr[6:1]))
                                              : xval(int'(mem_rd_addr[6:1]));
            else
                mem_rd_data <= 8'hEE;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [13:0] a, input logic [7:0] d);
        @(negedge clk);
        ywr_en = 1'b1; ywr_addr = a; ywr_data = d;
        @(negedge clk);
        ywr_en = 1'b0;
    endtask

    task automatic put_y(input int i, input logic [7:0] y);
        cpu_write({attr_page, 2'b00, 6'(i)}, y);
        ymodel[i] = y;
    endtask

    task automatic fill_y(input logic [7:0] y);
        for (int i = 0; i < 64; i++) put_y(i, y);
    endtask

    // expected draw list from the requirements
    task automatic model_line(input logic [7:0] cur);
        int t, h, sel, row;
        t = (int'(cur) + 1) % 256;
        h = tall_mode ? 16 : 8;
        sel = 0; exp_n = 0;
        for (int i = 0; i < 64 && sel < 16; i++) begin
            if (t >= int'(ymodel[i]) && t < int'(ymodel[i]) + h) begin
                if (exp_n < 8) begin
                    row = t - int'(ymodel[i]);
                    exp_x[exp_n] = int'(xval(i));
                    exp_a[exp_n] = (int'(tval(i)) * 32 + (pat_hi ? 8192 : 0) + row * 4) & 16383;
                    exp_n++;
                end
                sel++;
            end
        end
        exp_ovf = (sel > 8);
    endtask

    task automatic run_line(input logic [7:0] cur);
        int cyc;
        got_n = 0;
        @(negedge clk);
        cur_line = cur; line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        chk(!sprite_overflow && !eval_done, "R9 cleared after strobe", int'(sprite_overflow), 0);
        cyc = 0;
        while (!eval_done && cyc < 2000) begin
            if (draw_valid && got_n < 8) begin
                got_x[got_n] = int'(draw_x);
                got_a[got_n] = int'(draw_addr);
                got_num[got_n] = int'(draw_num);
                got_n++;
            end
            @(negedge clk);
            cyc++;
        end
        last_cycles = cyc;
        chk(eval_done, "R4 evaluation finished", int'(eval_done), 1);
    endtask

    task automatic compare(input string req);
        chk(got_n == exp_n, {req, " draw count"}, got_n, exp_n);
        for (int k = 0; k < 8; k++) begin
            if (k < exp_n && k < got_n) begin
                chk(got_x[k] == exp_x[k], {req, " R5 X byte"}, got_x[k], exp_x[k]);
                chk(got_a[k] == exp_a[k], {req, " R6 pattern address"}, got_a[k], exp_a[k]);
                chk(got_num[k] == 7 - k, {req, " R4 entry number"}, got_num[k], 7 - k);
            end
        end
        chk(sprite_overflow == exp_ovf, {req, " R7 overflow"}, int'(sprite_overflow), int'(exp_ovf));
    endtask

    task automatic t_reset;
        chk(!draw_valid, "R10 draw_valid after reset", int'(draw_valid), 0);
        chk(!sprite_overflow, "R10 overflow after reset", int'(sprite_overflow), 0);
        chk(!eval_done, "R10 eval_done after reset", int'(eval_done), 0);
    endtask

    task automatic t_empty_timing;
        fill_y(8'hF0);
        model_line(8'd10);
        run_line(8'd10);
        chk(last_cycles == 34, "R11 two entries per cycle", last_cycles, 34);
        compare("R11 empty");
    endtask

    task automatic t_basic;
        tall_mode = 1'b0; pat_hi = 1'b0;
        put_y(3, 8'd50); put_y(5, 8'd43); put_y(6, 8'd42); put_y(10, 8'd51);
        model_line(8'd49);
        run_line(8'd49);
        chk(exp_n == 2, "R2 model sanity", exp_n, 2);
        compare("R2 short sprites");
    endtask

    task automatic t_tall;
        tall_mode = 1'b1; pat_hi = 1'b1;
        put_y(7, 8'd35); put_y(8, 8'd34);
        model_line(8'd49);
        run_line(8'd49);
        compare("R2 R6 tall sprites");
        tall_mode = 1'b0; pat_hi = 1'b0;
    endtask

    task automatic t_wrap;
        attr_page = 6'h3F;
        fill_y(8'hF0);
        put_y(20, 8'd0); put_y(21, 8'd255);
        model_line(8'd255);
        run_line(8'd255);
        chk(exp_n == 1, "R1 model sanity", exp_n, 1);
        compare("R1 line wrap");
    endtask

    task automatic t_overflow;
        attr_page = 6'h12;
        fill_y(8'hF0);
        for (int i = 0; i < 20; i++) put_y(i * 3, 8'd96);
        model_line(8'd99);
        run_line(8'd99);
        chk(exp_ovf, "R3 model sanity", int'(exp_ovf), 1);
        compare("R3 R7 crowded line");
    endtask

    task automatic t_restart;
        model_line(8'd200);
        run_line(8'd200);
        compare("R9 restart");
    endtask

    task automatic t_cache_window;
        attr_page = 6'h05;
        fill_y(8'hF0);
        cpu_write({6'h05, 8'h40}, 8'd60);
        cpu_write({6'h06, 8'h00}, 8'd60);
        cpu_write({6'h05, 8'h3F}, 8'd60);
        ymodel[63] = 8'd60;
        model_line(8'd60);
        run_line(8'd60);
        chk(exp_n == 1, "R8 model sanity", exp_n, 1);
        compare("R8 write window");
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_empty_timing();
        t_basic();
        t_tall();
        t_wrap();
        t_overflow();
        t_restart();
        t_cache_window();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule